// File: doc/BRIEF.md
# Mixed-Format Fixed-Point Compare and Select Unit

This combinational unit works on signed two's-complement fixed-point codes whose binary exponents are fixed at elaboration. Every operand carries its own width and exponent: a code `c` with exponent `e` stands for the real value `c * 2^e`. Because the formats differ, no path compares or multiplexes raw bits. Each operand is first shifted onto a common grid, and only then compared or selected.

The unit returns six relational flags for a left-hand and a right-hand operand. It also returns their minimum and maximum, a conditional pick between two further operands, and the negation and magnitude of a single operand. Each value result is written into an output format of its own. Shifting into a coarser format drops the low bits, which rounds toward minus infinity. A value outside the output range is clamped to the nearest extreme code.

Top module: `fxCmpSel`

## Requirements
- R1: `isLt` is 1 exactly when the real value of `lhsVal` is below that of `rhsVal`, and `isGt` is 1 exactly when it is above. Both are compared at the smaller of the two exponents, with sign extension.
- R2: `isLe` equals `isLt | isEq`, and `isGe` equals `isGt | isEq`.
- R3: `isEq` is 1 when the two real values are identical, even when the codes differ because the formats differ. `isNe` is always the inverse of `isEq`.
- R4: `minVal` holds the smaller and `maxVal` the larger of the two real values, both written in the min/max output format. `minVal` never exceeds `maxVal` as a signed value.
- R5: `selVal` holds `trueVal` when `condSel` is 1 and `falseVal` when `condSel` is 0. The chosen value is written in the select output format.
- R6: When a result goes to a format with a larger exponent, the dropped bits round the value toward minus infinity. For example, -3·2^-6 becomes -2·2^-5.
- R7: A result beyond the output range gives the largest positive code (0 then all ones) or the most negative code (1 then all zeros).
- R8: `negVal` is minus the real value of `unaryIn`, in the unary output format. The most negative input code is negated with one extra bit, so it becomes a positive value before it is clamped.
- R9: `absVal` is the magnitude of the real value of `unaryIn`, in the unary output format. It is never negative.
- R10: Exactly one of `isLt`, `isEq` and `isGt` is 1 for any pair of inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lhsVal | input | LHS_W | Left-hand operand, exponent LHS_EXP |
| rhsVal | input | RHS_W | Right-hand operand, exponent RHS_EXP |
| isLt | output | 1 | lhs < rhs |
| isLe | output | 1 | lhs <= rhs |
| isGt | output | 1 | lhs > rhs |
| isGe | output | 1 | lhs >= rhs |
| isEq | output | 1 | lhs == rhs |
| isNe | output | 1 | lhs != rhs |
| minVal | output | MM_W | Smaller operand, exponent MM_EXP |
| maxVal | output | MM_W | Larger operand, exponent MM_EXP |
| condSel | input | 1 | Select control |
| trueVal | input | TV_W | Value chosen when condSel is 1, exponent TV_EXP |
| falseVal | input | FV_W | Value chosen when condSel is 0, exponent FV_EXP |
| selVal | output | SEL_W | Chosen value, exponent SEL_EXP |
| unaryIn | input | UN_W | Unary operand, exponent UN_EXP |
| negVal | output | UO_W | Negation, exponent UO_EXP |
| absVal | output | UO_W | Magnitude, exponent UO_EXP |

## Verification
The bench uses the default parameters, and these mix three kinds of alignment. The left operand sits at exponent -4 and the right operand at -6, so the left operand is shifted left before the compare. The min/max output sits at -5, so the right-hand results lose a bit and round down. The select output sits at -4, fed from -3 and -7, and is only 8 bits wide, so both clamp directions of R7 can be reached. The unary path goes from exponent -2 to -3 in 8 bits, so negating the most negative code overflows and exercises the extra bit of R8.

// File: rtl/fxPkg.sv
package fxPkg;

  typedef struct packed {
    logic takeLhsMin;
    logic takeLhsMax;
    logic takeTrue;
    logic flipUnary;
  } fxStrobe_t;

  function automatic int minI(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int maxI(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fxAlign.sv
// Moves a signed code from one fixed-point format to another.
// Left shifts are exact; right shifts floor; out-of-range values clamp.
module fxAlign #(
  parameter int IN_W    = 8,
  parameter int IN_EXP  = 0,
  parameter int OUT_W   = 8,
  parameter int OUT_EXP = 0
) (
  input  logic [IN_W-1:0]  inCode,
  output logic [OUT_W-1:0] outCode
);
  localparam int SHL = (IN_EXP > OUT_EXP) ? (IN_EXP - OUT_EXP) : 0;
  localparam int SHR = (OUT_EXP > IN_EXP) ? (OUT_EXP - IN_EXP) : 0;
  localparam int EW  = IN_W + SHL;

  logic signed [EW-1:0] grown;
  logic signed [EW-1:0] shifted;

  always_comb begin
    grown   = EW'($signed(inCode)) <<< SHL;
    shifted = grown >>> SHR;
  end

  generate
    if (EW > OUT_W) begin : gSat
      localparam logic signed [EW-1:0] HI_LIM = {{(EW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
      localparam logic signed [EW-1:0] LO_LIM = ~HI_LIM;
      always_comb begin
        if (shifted > HI_LIM)      outCode = {1'b0, {(OUT_W-1){1'b1}}};
        else if (shifted < LO_LIM) outCode = {1'b1, {(OUT_W-1){1'b0}}};
        else                       outCode = shifted[OUT_W-1:0];
      end
    end else begin : gExt
      assign outCode = OUT_W'(shifted);
    end
  endgenerate
endmodule

// File: rtl/fxCtrl.sv
// Turns the raw ordering results into predicates and steering strobes.
module fxCtrl
  import fxPkg::*;
(
  input  logic      lessRaw,
  input  logic      equalRaw,
  input  logic      greaterRaw,
  input  logic      condSel,
  input  logic      unarySign,
  output logic      isLt,
  output logic      isLe,
  output logic      isGt,
  output logic      isGe,
  output logic      isEq,
  output logic      isNe,
  output fxStrobe_t strobes
);
  always_comb begin
    isLt = lessRaw;
    isGt = greaterRaw;
    isEq = equalRaw;
    isNe = ~equalRaw;
    isLe = lessRaw | equalRaw;
    isGe = greaterRaw | equalRaw;
    strobes.takeLhsMin = lessRaw | equalRaw;
    strobes.takeLhsMax = greaterRaw | equalRaw;
    strobes.takeTrue   = condSel;
    strobes.flipUnary  = unarySign;
  end
endmodule

// File: rtl/fxData.sv
// Alignment, ordering and steering datapath.
module fxData
  import fxPkg::*;
#(
  parameter int LHS_W = 8,  parameter int LHS_EXP = -4,
  parameter int RHS_W = 10, parameter int RHS_EXP = -6,
  parameter int MM_W  = 10, parameter int MM_EXP  = -5,
  parameter int TV_W  = 8,  parameter int TV_EXP  = -3,
  parameter int FV_W  = 12, parameter int FV_EXP  = -7,
  parameter int SEL_W = 8,  parameter int SEL_EXP = -4,
  parameter int UN_W  = 8,  parameter int UN_EXP  = -2,
  parameter int UO_W  = 8,  parameter int UO_EXP  = -3
) (
  input  logic [LHS_W-1:0] lhsVal,
  input  logic [RHS_W-1:0] rhsVal,
  input  logic [TV_W-1:0]  trueVal,
  input  logic [FV_W-1:0]  falseVal,
  input  logic [UN_W-1:0]  unaryIn,
  input  fxStrobe_t        strobes,
  output logic             lessRaw,
  output logic             equalRaw,
  output logic             greaterRaw,
  output logic             unarySign,
  output logic [MM_W-1:0]  minVal,
  output logic [MM_W-1:0]  maxVal,
  output logic [SEL_W-1:0] selVal,
  output logic [UO_W-1:0]  negVal,
  output logic [UO_W-1:0]  absVal
);
  // common grid for the compare path
  localparam int CE = minI(LHS_EXP, RHS_EXP);
  localparam int CW = maxI(LHS_W + LHS_EXP - CE, RHS_W + RHS_EXP - CE);
  // common grid for the select path
  localparam int SE = minI(TV_EXP, FV_EXP);
  localparam int SW = maxI(TV_W + TV_EXP - SE, FV_W + FV_EXP - SE);
  // unary path keeps one guard bit so the most negative code negates
  localparam int UW = UN_W + 1;

  logic [CW-1:0] lhsC, rhsC, minC, maxC;
  logic [SW-1:0] trueC, falseC, pickC;
  logic [UW-1:0] unaryExt, unaryNeg, unaryMag;

  fxAlign #(.IN_W(LHS_W), .IN_EXP(LHS_EXP), .OUT_W(CW), .OUT_EXP(CE))
    uLhsAlign (.inCode(lhsVal), .outCode(lhsC));
  fxAlign #(.IN_W(RHS_W), .IN_EXP(RHS_EXP), .OUT_W(CW), .OUT_EXP(CE))
    uRhsAlign (.inCode(rhsVal), .outCode(rhsC));

  always_comb begin
    lessRaw    = $signed(lhsC) < $signed(rhsC);
    greaterRaw = $signed(lhsC) > $signed(rhsC);
    equalRaw   = (lhsC == rhsC);
    minC = strobes.takeLhsMin ? lhsC : rhsC;
    maxC = strobes.takeLhsMax ? lhsC : rhsC;
  end

  fxAlign #(.IN_W(CW), .IN_EXP(CE), .OUT_W(MM_W), .OUT_EXP(MM_EXP))
    uMinOut (.inCode(minC), .outCode(minVal));
  fxAlign #(.IN_W(CW), .IN_EXP(CE), .OUT_W(MM_W), .OUT_EXP(MM_EXP))
    uMaxOut (.inCode(maxC), .outCode(maxVal));

  fxAlign #(.IN_W(TV_W), .IN_EXP(TV_EXP), .OUT_W(SW), .OUT_EXP(SE))
    uTrueAlign (.inCode(trueVal), .outCode(trueC));
  fxAlign #(.IN_W(FV_W), .IN_EXP(FV_EXP), .OUT_W(SW), .OUT_EXP(SE))
    uFalseAlign (.inCode(falseVal), .outCode(falseC));

  assign pickC = strobes.takeTrue ? trueC : falseC;

  fxAlign #(.IN_W(SW), .IN_EXP(SE), .OUT_W(SEL_W), .OUT_EXP(SEL_EXP))
    uSelOut (.inCode(pickC), .outCode(selVal));

  always_comb begin
    unarySign = unaryIn[UN_W-1];
    unaryExt  = {unaryIn[UN_W-1], unaryIn};
    unaryNeg  = -unaryExt;
    unaryMag  = strobes.flipUnary ? unaryNeg : unaryExt;
  end

  fxAlign #(.IN_W(UW), .IN_EXP(UN_EXP), .OUT_W(UO_W), .OUT_EXP(UO_EXP))
    uNegOut (.inCode(unaryNeg), .outCode(negVal));
  fxAlign #(.IN_W(UW), .IN_EXP(UN_EXP), .OUT_W(UO_W), .OUT_EXP(UO_EXP))
    uAbsOut (.inCode(unaryMag), .outCode(absVal));
endmodule

// File: rtl/fxCmpSel.sv
module fxCmpSel
  import fxPkg::*;
#(
  parameter int LHS_W = 8,  parameter int LHS_EXP = -4,
  parameter int RHS_W = 10, parameter int RHS_EXP = -6,
  parameter int MM_W  = 10, parameter int MM_EXP  = -5,
  parameter int TV_W  = 8,  parameter int TV_EXP  = -3,
  parameter int FV_W  = 12, parameter int FV_EXP  = -7,
  parameter int SEL_W = 8,  parameter int SEL_EXP = -4,
  parameter int UN_W  = 8,  parameter int UN_EXP  = -2,
  parameter int UO_W  = 8,  parameter int UO_EXP  = -3
) (
  input  logic [LHS_W-1:0] lhsVal,
  input  logic [RHS_W-1:0] rhsVal,
  output logic             isLt,
  output logic             isLe,
  output logic             isGt,
  output logic             isGe,
  output logic             isEq,
  output logic             isNe,
  output logic [MM_W-1:0]  minVal,
  output logic [MM_W-1:0]  maxVal,
  input  logic             condSel,
  input  logic [TV_W-1:0]  trueVal,
  input  logic [FV_W-1:0]  falseVal,
  output logic [SEL_W-1:0] selVal,
  input  logic [UN_W-1:0]  unaryIn,
  output logic [UO_W-1:0]  negVal,
  output logic [UO_W-1:0]  absVal
);
  fxStrobe_t strobes;
  logic lessRaw, equalRaw, greaterRaw, unarySign;

  fxCtrl uCtrl (
    .lessRaw(lessRaw), .equalRaw(equalRaw), .greaterRaw(greaterRaw),
    .condSel(condSel), .unarySign(unarySign),
    .isLt(isLt), .isLe(isLe), .isGt(isGt), .isGe(isGe),
    .isEq(isEq), .isNe(isNe), .strobes(strobes)
  );

  fxData #(
    .LHS_W(LHS_W), .LHS_EXP(LHS_EXP), .RHS_W(RHS_W), .RHS_EXP(RHS_EXP),
    .MM_W(MM_W), .MM_EXP(MM_EXP), .TV_W(TV_W), .TV_EXP(TV_EXP),
    .FV_W(FV_W), .FV_EXP(FV_EXP), .SEL_W(SEL_W), .SEL_EXP(SEL_EXP),
    .UN_W(UN_W), .UN_EXP(UN_EXP), .UO_W(UO_W), .UO_EXP(UO_EXP)
  ) uData (
    .lhsVal(lhsVal), .rhsVal(rhsVal), .trueVal(trueVal), .falseVal(falseVal),
    .unaryIn(unaryIn), .strobes(strobes),
    .lessRaw(lessRaw), .equalRaw(equalRaw), .greaterRaw(greaterRaw),
    .unarySign(unarySign),
    .minVal(minVal), .maxVal(maxVal), .selVal(selVal),
    .negVal(negVal), .absVal(absVal)
  );
endmodule

// File: rtl/fxCmpSelChk.sv
module fxCmpSelChk #(
  parameter int MM_W = 10,
  parameter int UO_W = 8
) (
  input logic            isLt,
  input logic            isLe,
  input logic            isGt,
  input logic            isGe,
  input logic            isEq,
  input logic            isNe,
  input logic [MM_W-1:0] minVal,
  input logic [MM_W-1:0] maxVal,
  input logic [UO_W-1:0] negVal,
  input logic [UO_W-1:0] absVal
);
  always_comb begin
    assert_one_order_R10: assert ($onehot({isLt, isEq, isGt}));
    assert_le_ge_R2:      assert ((isLe == (isLt | isEq)) && (isGe == (isGt | isEq)));
    assert_eq_ne_R3:      assert (isEq != isNe);
    assert_min_max_R4:    assert ($signed(minVal) <= $signed(maxVal));
    assert_abs_pos_R9:    assert (!absVal[UO_W-1]);
    assert_neg_abs_R8:    assert ($signed(negVal) <= $signed(absVal));
  end
endmodule

bind fxCmpSel fxCmpSelChk #(.MM_W(MM_W), .UO_W(UO_W)) uChk (
  .isLt(isLt), .isLe(isLe), .isGt(isGt), .isGe(isGe), .isEq(isEq), .isNe(isNe),
  .minVal(minVal), .maxVal(maxVal), .negVal(negVal), .absVal(absVal)
);

// File: tb/sim_fxCmpSel.sv
module sim_fxCmpSel;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  lhsVal = '0;
  logic [9:0]  rhsVal = '0;
  logic        condSel = 1'b0;
  logic [7:0]  trueVal = '0;
  logic [11:0] falseVal = '0;
  logic [7:0]  unaryIn = '0;
  logic isLt, isLe, isGt, isGe, isEq, isNe;
  logic [9:0] minVal, maxVal;
  logic [7:0] selVal, negVal, absVal;

  fxCmpSel #(
    .LHS_W(8), .LHS_EXP(-4), .RHS_W(10), .RHS_EXP(-6),
    .MM_W(10), .MM_EXP(-5), .TV_W(8), .TV_EXP(-3),
    .FV_W(12), .FV_EXP(-7), .SEL_W(8), .SEL_EXP(-4),
    .UN_W(8), .UN_EXP(-2), .UO_W(8), .UO_EXP(-3)
  ) u0 (.*);

  typedef struct {
    bit lt, le, gt, ge, eq, ne;
    longint mn, mx, sel, neg, ab;
  } expItem_t;

  expItem_t sbQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  // value scaled to units of 2^-16
  function automatic longint scl(longint code, int e);
    return code <<< (e + 16);
  endfunction

  // floor into exponent e, clamp to w-bit signed range
  function automatic longint fit(longint s, int w, int e);
    longint q, hi;
    q  = s >>> (e + 16);
    hi = (longint'(1) <<< (w - 1)) - 1;
    if (q > hi) return hi;
    if (q < -hi - 1) return -hi - 1;
    return q;
  endfunction

  task automatic chk(string req, string what, longint act, longint expv);
    nChecks++;
    if (act != expv) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic drive(logic [7:0] a, logic [9:0] b, logic c,
                       logic [7:0] t, logic [11:0] f, logic [7:0] u);
    expItem_t it;
    longint sa, sb, st, sf, su;
    @(posedge clk);
    #1;
    lhsVal = a; rhsVal = b; condSel = c; trueVal = t; falseVal = f; unaryIn = u;
    sa = scl(longint'($signed(a)), -4);
    sb = scl(longint'($signed(b)), -6);
    st = scl(longint'($signed(t)), -3);
    sf = scl(longint'($signed(f)), -7);
    su = scl(longint'($signed(u)), -2);
    it.lt = sa < sb;  it.le = sa <= sb; it.gt = sa > sb;
    it.ge = sa >= sb; it.eq = sa == sb; it.ne = sa != sb;
    it.mn  = fit((sa < sb) ? sa : sb, 10, -5);
    it.mx  = fit((sa > sb) ? sa : sb, 10, -5);
    it.sel = fit(c ? st : sf, 8, -4);
    it.neg = fit(-su, 8, -3);
    it.ab  = fit((su < 0) ? -su : su, 8, -3);
    sbQ.push_back(it);
  endtask

  // monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      expItem_t e;
      e = sbQ.pop_front();
      chk("R1", "isLt", isLt, e.lt);
      chk("R1", "isGt", isGt, e.gt);
      chk("R2", "isLe", isLe, e.le);
      chk("R2", "isGe", isGe, e.ge);
      chk("R3", "isEq", isEq, e.eq);
      chk("R3", "isNe", isNe, e.ne);
      chk("R4", "minVal", longint'($signed(minVal)), e.mn);
      chk("R4", "maxVal", longint'($signed(maxVal)), e.mx);
      chk("R5", "selVal", longint'($signed(selVal)), e.sel);
      chk("R8", "negVal", longint'($signed(negVal)), e.neg);
      chk("R9", "absVal", longint'($signed(absVal)), e.ab);
    end
  end

  initial begin
    bit [31:0] lfsr;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset/idle state: all-zero operands
    drive(8'd0, 10'd0, 1'b0, 8'd0, 12'd0, 8'd0);
    // R3: 5*2^-4 equals 20*2^-6 across formats
    drive(8'd5, 10'd20, 1'b1, 8'd3, 12'd5, 8'd5);
    // R1: extreme lhs below extreme rhs
    drive(8'h80, 10'd511, 1'b0, 8'd1, 12'd9, 8'd3);
    // R1: lhs above negative rhs
    drive(8'd127, 10'h200, 1'b1, 8'd2, 12'd0, 8'hFD);
    // R6: min of 0 and -3*2^-6 floors to -2*2^-5
    drive(8'd0, 10'h3FD, 1'b0, 8'd0, 12'hFF7, 8'd1);
    // R7: select clamps high (true 127*2^-3 -> over 8-bit range at 2^-4)
    drive(8'd1, 10'd1, 1'b1, 8'd127, 12'd0, 8'd0);
    // R7: select clamps low (false -2048*2^-7 = -16)
    drive(8'd1, 10'd4, 1'b0, 8'd0, 12'h800, 8'd0);
    // R8, R9: most negative unary code
    drive(8'd2, 10'd8, 1'b0, 8'd0, 12'd16, 8'h80);
    // R5: condSel flips with identical data
    drive(8'd3, 10'd3, 1'b1, 8'hF0, 12'd100, 8'd7);
    drive(8'd3, 10'd3, 1'b0, 8'hF0, 12'd100, 8'd7);
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 300; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      drive(lfsr[7:0], (i % 4 == 0) ? {lfsr[7], lfsr[7], lfsr[7:0]} << 2 : lfsr[17:8],
            lfsr[18], lfsr[26:19], lfsr[31:20], lfsr[15:8]);
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule